// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

A host-side peripheral that holds three independent 16-bit down-counters. Each channel has its own count-enable input (one pulse is one counting clock), its own gate input and its own output. The host talks to the block over an 8-bit bus with an active-low chip select, active-low read and write strobes, and a 2-bit address. Address 0, 1 or 2 reaches that counter's count register and read path. Address 3 reaches a shared control register, which programs one channel per write or issues latch and read-back commands.

Each channel either raises its output once when a terminal count is reached, or produces a continuous square wave. Counting is pure binary or four-digit BCD. A count can be frozen into an output latch for a consistent two-byte read while the counter keeps running. A status byte can also be captured and read back.

All bus strobes are treated as synchronous to `clk`. A write acts in the first cycle its strobe is seen active. A read captures the selected byte into `rdata` in the first cycle of its strobe, and `rdata` holds that byte until the next read.

Top module: `tri_timer`

## Requirements
- R1: After reset every channel output is 0 and `rdata` is 0.
- R2: While `cs_n` is high, both strobes are ignored. A control write has no effect and `rdata` keeps its value.
- R3: A control byte written to address 3 has these fields: bits [7:6] select the channel, bits [5:4] the byte order, bits [3:1] the mode and bit 0 BCD. Byte order 01 means low byte only (the high byte is then 0). Byte order 10 means high byte only (the low byte is then 0). Byte order 11 means low byte then high byte. Counter reads follow the same byte order.
- R4: Any mode value other than 011 or 111 selects terminal-count mode. In this mode the control write and the completion of a count write both drive the output low. The first count pulse after the count write loads the counter. After N further gated pulses the output goes high, and it stays high.
- R5: In terminal-count mode, pulses arriving while the gate is low do not decrement the counter. The load pulse does not depend on the gate.
- R6: Mode 011 or 111 selects square-wave mode. The control write drives the output high. After the load pulse the output stays high for ceil(N/2) pulses and low for floor(N/2) pulses, then repeats with automatic reload. N is 2 or more. A count of 0 means 65536 in binary and 10000 in BCD.
- R7: When bit 0 of the control byte is 1, the counter decrements in BCD, each nibble holding one decimal digit (0099 follows 0100).
- R8: Byte order 00 at address 3 latches the selected counter. The latch holds while counting goes on, until the bytes its byte order requires have been read. A further latch command before then is ignored.
- R9: A read-back command is a control byte with bits [7:6] = 11. Bit 4 set captures status and bit 5 set latches the count. Bits 1, 2 and 3 pick channels 0, 1 and 2. The status byte is {output, null flag, control bits [5:0]}. The null flag is 1 from a count write until that count is loaded.
- R10: When status and count are both latched, the first read returns the status and the following reads return the latched count.
- R11: Without a latch, reads return the live counter bytes in the programmed byte order. In byte order 11 the low byte comes first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | 0-2 counter, 3 control register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, held until next read |
| ch_tick | input | 3 | Per-channel counting pulse |
| ch_gate | input | 3 | Per-channel gate |
| ch_out | output | 3 | Per-channel output |

## Verification
The bench targets the odd-count split of the square wave. A design that halves the count by truncation would give a high phase one pulse short. It runs the zero-count case in both number bases; a design that fails to wrap would stall or give 32768 where 5000 is due.

It checks that a second latch command does not overwrite a held latch, and that status is read ahead of a latched count. A latch that refreshes would return a moving value, and a wrong read order would swap bytes.

The bench also drives the gate low before and during counting. A design that gates the load pulse, or counts regardless of the gate, would raise its output at the wrong pulse.

// File: rtl/tri_timer.sv
module tri_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [2:0] ch_tick,
  input  logic [2:0] ch_gate,
  output logic [2:0] ch_out
);
  localparam int NCH = 3;
  localparam int CW  = 16;

  logic [5:0]    ctrl [NCH];
  logic [CW-1:0] cr [NCH], ce [NCH], ol [NCH];
  logic [7:0]    st [NCH];
  logic [NCH-1:0] out_q, nul, pend, run, extra, wr_hi, rd_hi, lat, stv;
  logic wr_q, rd_q;

  wire wr_act = ~cs_n & ~wr_n;
  wire rd_act = ~cs_n & ~rd_n;
  wire wr_go  = wr_act & ~wr_q;
  wire rd_go  = rd_act & ~rd_q;
  wire is_cnt = (addr != 2'd3);

  assign ch_out = out_q;

  function automatic [CW-1:0] dec1(input [CW-1:0] v, input bcd);
    logic [CW-1:0] r;
    logic b;
    r = v - 1'b1;
    if (bcd) begin
      r = v;
      b = 1'b1;
      for (int d = 0; d < CW/4; d++)
        if (b) begin
          if (v[4*d+:4] == 4'd0) r[4*d+:4] = 4'd9;
          else begin r[4*d+:4] = v[4*d+:4] - 4'd1; b = 1'b0; end
        end
    end
    return r;
  endfunction

  logic [7:0]    rd_byte;
  logic [CW-1:0] src;
  logic          rsel;
  always_comb begin
    rd_byte = 8'h00;
    src     = '0;
    rsel    = 1'b0;
    if (is_cnt) begin
      src     = lat[addr] ? ol[addr] : ce[addr];
      rsel    = (ctrl[addr][5:4] == 2'b10) || (ctrl[addr][5:4] == 2'b11 && rd_hi[addr]);
      rd_byte = stv[addr] ? st[addr] : (rsel ? src[15:8] : src[7:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q <= 1'b0; rd_q <= 1'b0; rdata <= 8'h00;
      out_q <= '0; nul <= '0; pend <= '0; run <= '0; extra <= '0;
      wr_hi <= '0; rd_hi <= '0; lat <= '0; stv <= '0;
      for (int i = 0; i < NCH; i++) begin
        ctrl[i] <= '0; cr[i] <= '0; ce[i] <= '0; ol[i] <= '0; st[i] <= '0;
      end
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
      for (int i = 0; i < NCH; i++)
        if (ch_tick[i]) begin
          if (pend[i]) begin
            ce[i]    <= (ctrl[i][2] & ctrl[i][1]) ? {cr[i][CW-1:1], 1'b0} : cr[i];
            extra[i] <= ctrl[i][2] & ctrl[i][1] & cr[i][0];
            run[i]   <= 1'b1;
            pend[i]  <= 1'b0;
            nul[i]   <= 1'b0;
          end else if (run[i] && ch_gate[i]) begin
            if (!(ctrl[i][2] & ctrl[i][1])) begin
              ce[i] <= dec1(ce[i], ctrl[i][0]);
              if (dec1(ce[i], ctrl[i][0]) == '0) out_q[i] <= 1'b1;
            end else if (ce[i] == CW'(2)) begin
              if (extra[i]) extra[i] <= 1'b0;
              else begin
                out_q[i] <= ~out_q[i];
                ce[i]    <= {cr[i][CW-1:1], 1'b0};
                extra[i] <= ~out_q[i] & cr[i][0];
                nul[i]   <= 1'b0;
              end
            end else
              ce[i] <= dec1(dec1(ce[i], ctrl[i][0]), ctrl[i][0]);
          end
        end

      if (rd_go && is_cnt) begin
        rdata <= rd_byte;
        if (stv[addr]) stv[addr] <= 1'b0;
        else begin
          if (ctrl[addr][5:4] == 2'b11) rd_hi[addr] <= ~rd_hi[addr];
          if (lat[addr] && (ctrl[addr][5:4] != 2'b11 || rd_hi[addr])) lat[addr] <= 1'b0;
        end
      end

      if (wr_go) begin
        if (!is_cnt) begin
          if (wdata[7:6] == 2'b11) begin
            for (int i = 0; i < NCH; i++)
              if (wdata[i+1]) begin
                if (wdata[5] && !lat[i]) begin ol[i] <= ce[i]; lat[i] <= 1'b1; end
                if (wdata[4] && !stv[i]) begin st[i] <= {out_q[i], nul[i], ctrl[i]}; stv[i] <= 1'b1; end
              end
          end else if (wdata[5:4] == 2'b00) begin
            if (!lat[wdata[7:6]]) begin
              ol[wdata[7:6]]  <= ce[wdata[7:6]];
              lat[wdata[7:6]] <= 1'b1;
            end
          end else begin
            ctrl[wdata[7:6]]  <= wdata[5:0];
            out_q[wdata[7:6]] <= wdata[2] & wdata[1];
            nul[wdata[7:6]]   <= 1'b1;
            run[wdata[7:6]]   <= 1'b0;
            pend[wdata[7:6]]  <= 1'b0;
            extra[wdata[7:6]] <= 1'b0;
            wr_hi[wdata[7:6]] <= 1'b0;
            rd_hi[wdata[7:6]] <= 1'b0;
            lat[wdata[7:6]]   <= 1'b0;
            stv[wdata[7:6]]   <= 1'b0;
          end
        end else if (ctrl[addr][5:4] != 2'b00) begin
          if (ctrl[addr][5:4] == 2'b01) cr[addr] <= {8'h00, wdata};
          else if (ctrl[addr][5:4] == 2'b10) cr[addr] <= {wdata, 8'h00};
          else if (!wr_hi[addr]) cr[addr][7:0] <= wdata;
          else cr[addr][15:8] <= wdata;
          if (ctrl[addr][5:4] == 2'b11) wr_hi[addr] <= ~wr_hi[addr];
          if (ctrl[addr][5:4] != 2'b11 || wr_hi[addr]) begin
            nul[addr] <= 1'b1;
            if (!(ctrl[addr][2] & ctrl[addr][1]) || !run[addr]) pend[addr] <= 1'b1;
            if (!(ctrl[addr][2] & ctrl[addr][1])) begin
              out_q[addr] <= 1'b0;
              run[addr]   <= 1'b0;
            end
          end
        end
      end
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !rd_go |=> $stable(rdata)); // R11

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    AST_CE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) !ch_tick[g] |=> $stable(ce[g])); // R5
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) lat[g] && $past(lat[g]) |-> $stable(ol[g])); // R8
    AST_TC_RISE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_out[g]) && !(ctrl[g][2] & ctrl[g][1]) |-> $past(ch_tick[g])); // R4
  end
endmodule

// File: tb/tri_timer_tb.sv
`timescale 1ns/1ps
module tri_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00, rdata, rb;
  logic [2:0] ch_tick = 3'b000, ch_gate = 3'b111, ch_out;
  int checks = 0, failures = 0;

  tri_timer dut_i (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ch_tick(ch_tick), .ch_gate(ch_gate), .ch_out(ch_out));

  always #2.5 clk = ~clk;

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic [15:0] to_bcd(input int v);
    int w;
    w = v % 10000;
    return {4'(w / 1000), 4'((w / 100) % 10), 4'((w / 10) % 10), 4'(w % 10)};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit sel = 1'b1);
    cs_n = ~sel; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d, input bit sel = 1'b1);
    cs_n = ~sel; rd_n = 1'b0; addr = a;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; d = rdata;
    @(negedge clk);
  endtask

  task automatic tick_n(input int ch, input int n);
    repeat (n) begin
      ch_tick[ch] = 1'b1;
      @(negedge clk);
      ch_tick[ch] = 1'b0;
    end
  endtask

  task automatic phase(input int ch, input int limit, output int n);
    logic v;
    n = 0;
    v = ch_out[ch];
    do begin
      tick_n(ch, 1);
      n++;
    end while (ch_out[ch] == v && n < limit);
  endtask

  task automatic prog(input int ch, input logic [5:0] cw, input logic [15:0] cnt);
    wr(2'd3, {2'(ch), cw});
    wr(2'(ch), cnt[7:0]);
    wr(2'(ch), cnt[15:8]);
  endtask

  initial begin
    int h, l, h2, n, k, ch;
    logic [7:0] lo, hi;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 outputs", ch_out, 0);
    chk("R1 rdata", rdata, 0);

    // R9 R10 status and count read-back on channel 0
    prog(0, 6'h30, 16'h0010);
    wr(2'd3, 8'hD2);
    rd(2'd0, rb); chk("R9 status before load", rb, 8'h70);
    tick_n(0, 1);
    wr(2'd3, 8'hF2);
    rd(2'd0, rb); chk("R10 status first", rb, 8'h30);
    rd(2'd0, lo); chk("R10 latched low", lo, 8'h10);
    rd(2'd0, hi); chk("R10 latched high", hi, 8'h00);
    tick_n(0, 15); chk("R4 not yet", ch_out[0], 0);
    tick_n(0, 1);  chk("R4 terminal", ch_out[0], 1);
    wr(2'd3, 8'hD2);
    rd(2'd0, rb); chk("R9 status out high", rb, 8'hB0);

    // R2 deselected strobes ignored
    wr(2'd3, 8'h30, 1'b0);
    chk("R2 ignored control write", ch_out[0], 1);
    rd(2'd0, rb, 1'b0);
    chk("R2 ignored read", rdata, 8'hB0);

    // R3 low byte only and high byte only
    wr(2'd3, 8'h10); wr(2'd0, 8'h07);
    tick_n(0, 1); wr(2'd3, 8'h00);
    rd(2'd0, rb); chk("R3 low only", rb, 8'h07);
    tick_n(0, 6); chk("R3 low only count", ch_out[0], 0);
    tick_n(0, 1); chk("R3 low only terminal", ch_out[0], 1);
    wr(2'd3, 8'h20); wr(2'd0, 8'h02);
    tick_n(0, 2); wr(2'd3, 8'h00);
    rd(2'd0, rb); chk("R3 high only", rb, 8'h01);

    // R8 latch hold and ignored re-latch on channel 2
    prog(2, 6'h30, 16'h1234);
    tick_n(2, 5);
    wr(2'd3, 8'h80);
    tick_n(2, 3);
    rd(2'd2, lo); chk("R8 latched low", lo, 8'h30);
    tick_n(2, 2);
    wr(2'd3, 8'h80);
    rd(2'd2, hi); chk("R8 latched high", hi, 8'h12);
    rd(2'd2, lo); chk("R11 live low", lo, 8'h2B);
    rd(2'd2, hi); chk("R11 live high", hi, 8'h12);

    // R5 gate
    ch_gate[1] = 1'b0;
    prog(1, 6'h30, 16'h0003);
    tick_n(1, 11);
    chk("R5 gated hold", ch_out[1], 0);
    rd(2'd1, lo); chk("R5 count kept low", lo, 8'h03);
    rd(2'd1, hi); chk("R5 count kept high", hi, 8'h00);
    ch_gate[1] = 1'b1;
    tick_n(1, 2); chk("R5 resume", ch_out[1], 0);
    tick_n(1, 1); chk("R5 terminal", ch_out[1], 1);

    // R7 directed BCD step
    prog(1, 6'h31, 16'h0100);
    tick_n(1, 2);
    wr(2'd3, 8'h40);
    rd(2'd1, lo); chk("R7 bcd low", lo, 8'h99);
    rd(2'd1, hi); chk("R7 bcd high", hi, 8'h00);

    // R4 random terminal counts
    for (int it = 0; it < 12; it++) begin
      ch = int'($urandom % 3);
      n = 2 + int'($urandom % 300);
      prog(ch, 6'h30, 16'(n));
      chk("R4 low after write", ch_out[ch], 0);
      tick_n(ch, n);
      chk("R4 random before", ch_out[ch], 0);
      tick_n(ch, 1);
      chk("R4 random terminal", ch_out[ch], 1);
    end

    // R7 random BCD values
    for (int it = 0; it < 8; it++) begin
      ch = int'($urandom % 3);
      n = 20 + int'($urandom % 9980);
      k = 1 + int'($urandom % 15);
      prog(ch, 6'h31, to_bcd(n));
      tick_n(ch, 1 + k);
      wr(2'd3, {2'(ch), 6'h00});
      rd(2'(ch), lo);
      rd(2'(ch), hi);
      chk("R7 random bcd", {hi, lo}, to_bcd(n - k));
    end

    // R6 random square waves, binary and BCD
    for (int it = 0; it < 8; it++) begin
      ch = int'($urandom % 3);
      n = 2 + int'($urandom % 30);
      prog(ch, (it % 2) ? 6'h37 : 6'h36, (it % 2) ? to_bcd(n) : 16'(n));
      chk("R6 high at start", ch_out[ch], 1);
      tick_n(ch, 1);
      phase(ch, 100, h);  chk("R6 high phase", h, (n + 1) / 2);
      phase(ch, 100, l);  chk("R6 low phase", l, n / 2);
      phase(ch, 100, h2); chk("R6 high again", h2, (n + 1) / 2);
    end

    // R6 zero count
    prog(1, 6'h36, 16'h0000);
    tick_n(1, 1);
    phase(1, 40000, h); chk("R6 binary zero", h, 32768);
    prog(1, 6'h37, 16'h0000);
    tick_n(1, 1);
    phase(1, 6000, h); chk("R6 bcd zero", h, 5000);

    finish_run();
  end
endmodule